// File: doc/BRIEF.md
# Wiper Register I2C Target

This block is the serial control port of a small dual-wiper device. It holds three 6-bit registers (wiper 0, wiper 1 and a configuration value). It follows an I2C bus that is sampled with the system clock, and it answers on SDA only by pulling the line low. The 7-bit target address is the fixed pattern `0101` in its upper four bits. Three strap pins supply the lower three bits, so eight of these devices can share one bus.

Write transactions may carry any number of data bytes. The two top bits of each byte name the destination register and the low six bits carry the new value, so one transaction can update all three registers. Read transactions have no register pointer. A read always begins at wiper 0 and returns the registers in a fixed cycle for as long as the master acknowledges. Each read byte carries its own register code in its top two bits.

While the nonvolatile store is busy, a busy input makes the block decline its address. A master can therefore poll until the device is ready again.

Top module: `wiper_i2c_target`

## Requirements
- R1: An address byte whose upper seven bits equal `0101` followed by `strap_i[2:0]` is acknowledged by pulling SDA low during the ninth clock. Bit 0 of the address byte selects a read when 1 and a write when 0. Any other address pattern, including a wrong upper nibble, is not acknowledged.
- R2: After an address that does not match, the block neither drives SDA nor changes any register until the next START. Data bytes that follow are not acknowledged and are not applied.
- R3: Every byte is transferred most significant bit first. The ninth clock of every byte carries the acknowledge, where low means ACK and high means NACK. The block acknowledges every data byte it receives in an addressed write.
- R4: `sda_pull_o` changes only after a falling SCL edge, or on a START or STOP. It never changes while SCL is high.
- R5: A read returns wiper 0, then wiper 1, then configuration, and then wraps to wiper 0 again for as long as the master sends ACK. Each returned byte is the register's 2-bit code followed by its 6-bit value: `00` for wiper 0, `01` for wiper 1, `10` for configuration.
- R6: A NACK from the master ends the read. The block stops driving SDA and stays released through any further clocks until a START.
- R7: Every read transaction, including a single-byte read, begins with wiper 0.
- R8: While `nv_busy_i` is high at the end of the address byte, the address is not acknowledged and the write that follows is not applied.
- R9: In a write, each data byte's bits [7:6] select the target (`00` wiper 0, `01` wiper 1, `10` configuration) and bits [5:0] become its value. Any number of bytes, in any order, may follow one address.
- R10: A data byte whose bits [7:6] are `11` is acknowledged but changes no register.
- R11: A START or repeated START in the middle of a byte abandons that byte without effect. The block then begins a new address phase.
- R12: After reset all three registers read zero and SDA is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the bus |
| rst_n | input | 1 | Synchronous reset, active low |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| strap_i | input | 3 | Low three bits of the target address |
| nv_busy_i | input | 1 | Nonvolatile write in progress; suppresses address ACK |
| sda_pull_o | output | 1 | When high, the pad pulls SDA low |
| wiper0_o | output | 6 | Wiper 0 setting |
| wiper1_o | output | 6 | Wiper 1 setting |
| cfg_o | output | 6 | Configuration value |

## Verification
The assertions assume that the system clock is much faster than SCL. Each SCL phase must last long enough that the block's SDA response settles while SCL is still low. The assertions also assume that the master moves SDA while SCL is high only to signal START or STOP, and that it never does so while the block is pulling SDA. The bench keeps each quarter of an SCL bit at eight system clocks and changes its own SDA only a quarter bit after SCL has fallen. It issues repeated STARTs only at points where the block has released the line.

// File: rtl/wpi2c_pkg.sv
// Shared types and constants for the wiper register I2C target.
// Assumes byte-wide transfers with a 2-bit register code and a 6-bit value.
package wpi2c_pkg;
    localparam int BYTE_W    = 8;
    localparam int TAG_W     = 2;
    localparam int VAL_W     = BYTE_W - TAG_W;
    localparam int NUM_SLOTS = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WRITE,
        ST_WRITE_ACK,
        ST_READ,
        ST_READ_ACK
    } bus_state_t;
endpackage

// File: rtl/i2c_line_sync.sv
// Synchronises SCL and SDA to clk and derives edge and bus-condition events.
// Assumes the clock is several times faster than SCL; an idle bus reads high.
module i2c_line_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [SYNC_STAGES-1:0] scl_pipe, sda_pipe;
    logic scl_q, sda_q;

    generate
        if (SYNC_STAGES >= 2) begin : g_multi
            // Shift both lines through the synchroniser chain.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    scl_pipe <= '1;
                    sda_pipe <= '1;
                end else begin
                    scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_i};
                    sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_i};
                end
            end
        end else begin : g_single
            // Single capture flop when only one stage is requested.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    scl_pipe <= '1;
                    sda_pipe <= '1;
                end else begin
                    scl_pipe <= scl_i;
                    sda_pipe <= sda_i;
                end
            end
        end
    endgenerate

    // Keep the previous synchronised levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_pipe[SYNC_STAGES-1];
            sda_q <= sda_pipe[SYNC_STAGES-1];
        end
    end

    assign scl_lvl   = scl_pipe[SYNC_STAGES-1];
    assign sda_lvl   = sda_pipe[SYNC_STAGES-1];
    assign scl_rise  = scl_lvl & ~scl_q;
    assign scl_fall  = ~scl_lvl & scl_q;
    assign start_det = scl_lvl & scl_q & sda_q & ~sda_lvl;
    assign stop_det  = scl_lvl & scl_q & ~sda_q & sda_lvl;
endmodule

// File: rtl/wiper_reg_bank.sv
// Holds the three 6-bit registers; decodes write bytes by their 2-bit code
// and forms the tagged read-back byte for the selected slot.
// Assumes wr_en is a one-cycle pulse per received data byte.
module wiper_reg_bank
    import wpi2c_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_byte,
    input  logic [TAG_W-1:0]  rd_sel,
    output logic [BYTE_W-1:0] rd_byte,
    output logic [VAL_W-1:0]  wiper0_o,
    output logic [VAL_W-1:0]  wiper1_o,
    output logic [VAL_W-1:0]  cfg_o
);
    logic [VAL_W-1:0] slot_q [NUM_SLOTS];
    logic [TAG_W-1:0] wr_tag;

    assign wr_tag = wr_byte[BYTE_W-1 -: TAG_W];

    // Update the slot named by the byte's code; code 3 matches no slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_SLOTS; i++) slot_q[i] <= '0;
        end else if (wr_en) begin
            for (int i = 0; i < NUM_SLOTS; i++)
                if (wr_tag == TAG_W'(i)) slot_q[i] <= wr_byte[VAL_W-1:0];
        end
    end

    // Form the read-back byte as {code, value} for the selected slot.
    always_comb begin
        case (rd_sel)
            2'd0:    rd_byte = {2'd0, slot_q[0]};
            2'd1:    rd_byte = {2'd1, slot_q[1]};
            2'd2:    rd_byte = {2'd2, slot_q[2]};
            default: rd_byte = '0;
        endcase
    end

    assign wiper0_o = slot_q[0];
    assign wiper1_o = slot_q[1];
    assign cfg_o    = slot_q[2];
endmodule

// File: rtl/i2c_target_fsm.sv
// Byte-level target protocol: address match, write reception, rotating read
// and acknowledge generation. SDA is changed only on a synchronised SCL fall.
// Assumes bus events come from i2c_line_sync and occur at most once per cycle.
module i2c_target_fsm
    import wpi2c_pkg::*;
#(
    parameter logic [3:0] ADDR_HI = 4'b0101
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_lvl,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [2:0]        strap_i,
    input  logic              nv_busy_i,
    input  logic [BYTE_W-1:0] rd_byte,
    output logic [TAG_W-1:0]  rd_sel,
    output logic              wr_en,
    output logic [BYTE_W-1:0] wr_byte,
    output logic              sda_pull,
    output bus_state_t        state,
    output logic [TAG_W-1:0]  rd_ptr
);
    bus_state_t        state_q;
    logic [2:0]        bit_q;
    logic [BYTE_W-1:0] sh_q;
    logic              oe_q, rw_q, wr_en_q;
    logic [BYTE_W-1:0] wr_byte_q;
    logic [TAG_W-1:0]  ptr_q, nxt_ptr;
    logic [BYTE_W-1:0] rx_byte;
    logic              addr_hit;

    assign rx_byte  = {sh_q[BYTE_W-2:0], sda_lvl};
    assign addr_hit = (rx_byte[BYTE_W-1:1] == {ADDR_HI, strap_i}) && !nv_busy_i;
    assign nxt_ptr  = (ptr_q == TAG_W'(NUM_SLOTS-1)) ? '0 : ptr_q + 1'b1;
    assign rd_sel   = (state_q == ST_READ_ACK) ? nxt_ptr : '0;

    // Main protocol sequencer; START/STOP override every state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            bit_q     <= '0;
            sh_q      <= '0;
            oe_q      <= 1'b0;
            rw_q      <= 1'b0;
            ptr_q     <= '0;
            wr_en_q   <= 1'b0;
            wr_byte_q <= '0;
        end else begin
            wr_en_q <= 1'b0;
            if (start_det) begin
                state_q <= ST_ADDR;
                bit_q   <= '0;
                oe_q    <= 1'b0;
            end else if (stop_det) begin
                state_q <= ST_IDLE;
                oe_q    <= 1'b0;
            end else begin
                case (state_q)
                    ST_ADDR: if (scl_rise) begin
                        sh_q  <= rx_byte;
                        bit_q <= bit_q + 3'd1;
                        if (bit_q == 3'd7) begin
                            state_q <= addr_hit ? ST_ADDR_ACK : ST_IDLE;
                            rw_q    <= rx_byte[0];
                            ptr_q   <= '0;
                        end
                    end
                    ST_ADDR_ACK: if (scl_fall) begin
                        if (!oe_q) begin
                            oe_q <= 1'b1;
                        end else if (rw_q) begin
                            state_q <= ST_READ;
                            sh_q    <= rd_byte << 1;
                            oe_q    <= ~rd_byte[BYTE_W-1];
                            bit_q   <= '0;
                        end else begin
                            state_q <= ST_WRITE;
                            oe_q    <= 1'b0;
                            bit_q   <= '0;
                        end
                    end
                    ST_WRITE: if (scl_rise) begin
                        sh_q  <= rx_byte;
                        bit_q <= bit_q + 3'd1;
                        if (bit_q == 3'd7) begin
                            wr_en_q   <= 1'b1;
                            wr_byte_q <= rx_byte;
                            state_q   <= ST_WRITE_ACK;
                        end
                    end
                    ST_WRITE_ACK: if (scl_fall) begin
                        if (!oe_q) begin
                            oe_q <= 1'b1;
                        end else begin
                            oe_q    <= 1'b0;
                            state_q <= ST_WRITE;
                            bit_q   <= '0;
                        end
                    end
                    ST_READ: begin
                        if (scl_fall) begin
                            oe_q <= ~sh_q[BYTE_W-1];
                            sh_q <= sh_q << 1;
                        end
                        if (scl_rise) begin
                            bit_q <= bit_q + 3'd1;
                            if (bit_q == 3'd7) state_q <= ST_READ_ACK;
                        end
                    end
                    ST_READ_ACK: begin
                        if (scl_fall) oe_q <= 1'b0;
                        if (scl_rise) begin
                            if (sda_lvl) begin
                                state_q <= ST_IDLE;
                            end else begin
                                ptr_q   <= nxt_ptr;
                                sh_q    <= rd_byte;
                                bit_q   <= '0;
                                state_q <= ST_READ;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign wr_en    = wr_en_q;
    assign wr_byte  = wr_byte_q;
    assign sda_pull = oe_q;
    assign state    = state_q;
    assign rd_ptr   = ptr_q;
endmodule

// File: rtl/wiper_i2c_target.sv
// Top of the wiper register I2C target: line synchroniser, protocol
// sequencer and register bank. Assumes an external open-drain pad driven
// by sda_pull_o and a system clock well above the SCL rate.
module wiper_i2c_target
    import wpi2c_pkg::*;
#(
    parameter logic [3:0] ADDR_HI     = 4'b0101,
    parameter int         SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_i,
    input  logic             sda_i,
    input  logic [2:0]       strap_i,
    input  logic             nv_busy_i,
    output logic             sda_pull_o,
    output logic [VAL_W-1:0] wiper0_o,
    output logic [VAL_W-1:0] wiper1_o,
    output logic [VAL_W-1:0] cfg_o
);
    logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
    logic              wr_en;
    logic [BYTE_W-1:0] wr_byte, rd_byte;
    logic [TAG_W-1:0]  rd_sel, rd_ptr;
    bus_state_t        state;

    i2c_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det)
    );

    i2c_target_fsm #(.ADDR_HI(ADDR_HI)) u_fsm (
        .clk(clk), .rst_n(rst_n), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
        .strap_i(strap_i), .nv_busy_i(nv_busy_i), .rd_byte(rd_byte),
        .rd_sel(rd_sel), .wr_en(wr_en), .wr_byte(wr_byte),
        .sda_pull(sda_pull_o), .state(state), .rd_ptr(rd_ptr)
    );

    wiper_reg_bank u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_byte(wr_byte),
        .rd_sel(rd_sel), .rd_byte(rd_byte), .wiper0_o(wiper0_o),
        .wiper1_o(wiper1_o), .cfg_o(cfg_o)
    );
endmodule

// File: rtl/wiper_i2c_target_chk.sv
// Protocol checker for wiper_i2c_target, attached by bind below.
// Assumes SDA moves during SCL high only for START/STOP, never while pulled.
module wiper_i2c_target_chk
    import wpi2c_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             scl_fall,
    input logic             start_det,
    input logic             stop_det,
    input logic             nv_busy_i,
    input logic             sda_pull_o,
    input logic             wr_en,
    input bus_state_t       state,
    input logic [TAG_W-1:0] rd_ptr,
    input logic [VAL_W-1:0] wiper0_o,
    input logic [VAL_W-1:0] wiper1_o,
    input logic [VAL_W-1:0] cfg_o
);
    // R4: the pull only moves after an SCL fall or a bus condition.
    p_pull_after_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_pull_o != $past(sda_pull_o)) |-> $past(scl_fall || start_det || stop_det));

    // R2: no pull while idle, receiving address bits or receiving data bits.
    p_quiet_receive_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state inside {ST_IDLE, ST_ADDR, ST_WRITE}) |-> !sda_pull_o);

    // R8: the acknowledge phase is entered only when busy was low.
    p_busy_blocks_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ADDR_ACK && $past(state) == ST_ADDR) |-> !$past(nv_busy_i));

    // R10: registers change only in the cycle after a write strobe.
    p_regs_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(wiper0_o) && $stable(wiper1_o) && $stable(cfg_o)));

    // R5: the rotating read pointer stays within the three slots.
    p_ptr_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ptr < TAG_W'(NUM_SLOTS));
endmodule

bind wiper_i2c_target wiper_i2c_target_chk u_chk (
    .clk(clk), .rst_n(rst_n), .scl_fall(scl_fall), .start_det(start_det),
    .stop_det(stop_det), .nv_busy_i(nv_busy_i), .sda_pull_o(sda_pull_o),
    .wr_en(wr_en), .state(state), .rd_ptr(rd_ptr), .wiper0_o(wiper0_o),
    .wiper1_o(wiper1_o), .cfg_o(cfg_o)
);

// File: tb/wiper_i2c_target_bench.sv
// Self-checking bench: bit-banged I2C master with a register model.
module wiper_i2c_target_bench;
    localparam int Q = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1;
    logic m_low = 1'b0;
    logic [2:0] strap = 3'd0;
    logic busy = 1'b0;
    logic sda_bus, sda_pull;
    logic [5:0] w0, w1, cfg;
    logic [5:0] m_w0 = '0, m_w1 = '0, m_cfg = '0;
    int n_checks = 0, n_err = 0, r4_viol = 0;
    logic prev_pull = 1'b0;

    always #2 clk = ~clk;

    assign sda_bus = !(m_low || sda_pull);

    wiper_i2c_target u_wiper_i2c_target (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus),
        .strap_i(strap), .nv_busy_i(busy), .sda_pull_o(sda_pull),
        .wiper0_o(w0), .wiper1_o(w1), .cfg_o(cfg)
    );

    // R4 monitor: the pull must not change while SCL is high.
    always @(negedge clk) begin
        if (rst_n && sda_pull !== prev_pull && m_scl) r4_viol++;
        prev_pull <= sda_pull;
    end

    task automatic report;
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    endtask

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start;
        m_low = 1'b0; tick(Q);
        m_scl = 1'b1; tick(Q);
        m_low = 1'b1; tick(Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic bus_stop;
        m_low = 1'b1; tick(Q);
        m_scl = 1'b1; tick(Q);
        m_low = 1'b0; tick(Q);
    endtask

    task automatic put_bit(input logic b);
        m_low = !b; tick(Q);
        m_scl = 1'b1; tick(2 * Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic get_bit(output logic b);
        m_low = 1'b0; tick(Q);
        m_scl = 1'b1; tick(Q);
        b = sda_bus; tick(Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic write_byte(input logic [7:0] d, output logic acked);
        logic b;
        for (int i = 7; i >= 0; i--) put_bit(d[i]);
        get_bit(b);
        acked = !b;
    endtask

    task automatic read_byte(input logic ack, output logic [7:0] d);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            d[i] = b;
        end
        put_bit(!ack);
    endtask

    function automatic logic [7:0] expect_slot(input int k);
        case (k % 3)
            0:       return {2'd0, m_w0};
            1:       return {2'd1, m_w1};
            default: return {2'd2, m_cfg};
        endcase
    endfunction

    function automatic void model_write(input logic [7:0] d);
        case (d[7:6])
            2'd0:    m_w0 = d[5:0];
            2'd1:    m_w1 = d[5:0];
            2'd2:    m_cfg = d[5:0];
            default: ;
        endcase
    endfunction

    task automatic check_regs(input string req);
        check(req, {2'b0, w0}, {2'b0, m_w0});
        check(req, {2'b0, w1}, {2'b0, m_w1});
        check(req, {2'b0, cfg}, {2'b0, m_cfg});
    endtask

    // Address write, then a list of data bytes, all acks expected.
    task automatic write_txn(input logic [7:0] d0, input logic [7:0] d1,
                             input logic [7:0] d2, input int n);
        logic a;
        logic all_ok;
        logic [7:0] d [3];
        d[0] = d0; d[1] = d1; d[2] = d2;
        bus_start;
        write_byte({4'b0101, strap, 1'b0}, a);
        all_ok = a;
        for (int i = 0; i < n; i++) begin
            write_byte(d[i], a);
            all_ok = all_ok & a;
            model_write(d[i]);
        end
        bus_stop;
        check("R3 data bytes acknowledged", {7'd0, all_ok}, 8'd1);
    endtask

    initial begin
        logic a;
        logic b;
        logic [7:0] rd;

        tick(5);
        check("R12 wiper0 after reset", {2'b0, w0}, 8'd0);
        check("R12 wiper1 after reset", {2'b0, w1}, 8'd0);
        check("R12 cfg after reset", {2'b0, cfg}, 8'd0);
        check("R12 SDA released", {7'd0, sda_pull}, 8'd0);
        rst_n = 1'b1;
        tick(5);

        // R1/R2: sweep every strap against every low address triple.
        for (int s = 0; s < 8; s++) begin
            for (int ad = 0; ad < 8; ad++) begin
                strap = 3'(s);
                bus_start;
                write_byte({4'b0101, 3'(ad), 1'b0}, a);
                check(ad == s ? "R1 matching address ack" : "R2 foreign address nack",
                      {7'd0, a}, {7'd0, ad == s});
                if (ad != s) begin
                    write_byte({2'b00, 6'(ad * 8 + s + 1)}, a);
                    check("R2 data after foreign address ignored", {7'd0, a}, 8'd0);
                end
                bus_stop;
                if (ad != s) check("R2 wiper0 untouched", {2'b0, w0}, {2'b0, m_w0});
            end
        end

        // R1: a wrong upper nibble is not acknowledged.
        strap = 3'd3;
        bus_start;
        write_byte({4'b1101, 3'd3, 1'b0}, a);
        bus_stop;
        check("R1 wrong upper nibble nack", {7'd0, a}, 8'd0);

        // R9: three targets in one transaction, swept over values.
        strap = 3'd5;
        for (int v = 0; v < 64; v += 3) begin
            write_txn({2'd0, 6'(v)}, {2'd1, ~6'(v)}, {2'd2, 6'(v) ^ 6'h15}, 3);
            check_regs("R9 multi-byte write");
        end
        // R9: out-of-order targets and a repeated target.
        write_txn({2'd2, 6'h3C}, {2'd0, 6'h01}, {2'd0, 6'h2E}, 3);
        check_regs("R9 reordered write");

        // R10: code 11 is acknowledged and changes nothing.
        write_txn({2'd3, 6'h2A}, 8'h00, 8'h00, 1);
        check_regs("R10 code 11 ignored");

        // R5/R6: long rotating read, then clocks after NACK.
        for (int pass = 0; pass < 2; pass++) begin
            if (pass == 1) write_txn({2'd1, 6'h07}, {2'd2, 6'h30}, {2'd0, 6'h19}, 3);
            bus_start;
            write_byte({4'b0101, strap, 1'b1}, a);
            check("R1 read address ack", {7'd0, a}, 8'd1);
            for (int k = 0; k < 7; k++) begin
                read_byte(k != 6, rd);
                check("R5 rotating read order", rd, expect_slot(k));
            end
            get_bit(b);
            check("R6 released after NACK", {7'd0, b}, 8'd1);
            get_bit(b);
            check("R6 still released", {7'd0, sda_pull}, 8'd0);
            bus_stop;
        end

        // R7: single-byte reads always return wiper 0.
        for (int k = 0; k < 2; k++) begin
            bus_start;
            write_byte({4'b0101, strap, 1'b1}, a);
            read_byte(1'b0, rd);
            bus_stop;
            check("R7 single read is wiper0", rd, expect_slot(0));
        end

        // R8: busy suppresses the address ack and the write.
        busy = 1'b1;
        bus_start;
        write_byte({4'b0101, strap, 1'b0}, a);
        check("R8 no ack while busy", {7'd0, a}, 8'd0);
        write_byte({2'd0, 6'h3F}, a);
        bus_stop;
        check("R8 write while busy ignored", {2'b0, w0}, {2'b0, m_w0});
        busy = 1'b0;
        bus_start;
        write_byte({4'b0101, strap, 1'b0}, a);
        bus_stop;
        check("R8 ack once idle", {7'd0, a}, 8'd1);

        // R11: repeated START mid data byte abandons it.
        bus_start;
        write_byte({4'b0101, strap, 1'b0}, a);
        put_bit(1'b0); put_bit(1'b1); put_bit(1'b1); put_bit(1'b0);
        bus_start;
        write_byte({4'b0101, strap, 1'b1}, a);
        check("R11 new address after restart", {7'd0, a}, 8'd1);
        read_byte(1'b1, rd);
        check("R11 read after restart wiper0", rd, expect_slot(0));
        read_byte(1'b0, rd);
        check("R11 aborted byte not applied", rd, expect_slot(1));
        bus_stop;
        // R11: START mid address byte, then a full write.
        bus_start;
        put_bit(1'b0); put_bit(1'b1); put_bit(1'b0);
        write_txn({2'd1, 6'h2B}, 8'h00, 8'h00, 1);
        check_regs("R11 write after aborted address");

        check("R4 no pull change while SCL high", 8'(r4_viol), 8'd0);
        report;
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_checks++;
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        report;
        $finish;
    end
endmodule